// File: doc/BRIEF.md
# Bit-packed key-value word packer and unpacker

The block squeezes a stream of key-value pairs into wide storage words and turns such words back into pairs. Keys and values have parameterised widths and are stored at exactly those widths, with no padding to bytes or to powers of two. Each 256-bit word holds as many whole pairs as fit, which is floor(256 / (key width + value width)). A pair is never split across two words, and the leftover top bits of every word are zero.

The packing side takes one pair per handshake and emits a word when all its slots are full or when the pair marked end-of-stream arrives. A flushed partial word carries the number of pairs it holds. The unpacking side takes a word with its pair count and emits the pairs lowest slot first, so packing followed by unpacking returns the original stream in order. Both sides use valid/ready handshakes and can be chained back to back.

Top module: `kv_bit_packer`

## Requirements
- R1: After reset, in_ready and uw_ready are 1, and pk_valid and out_valid are 0.
- R2: Pair number i of a word (counting from 0) sits in bits [i*(KEY_W+VAL_W) +: KEY_W+VAL_W] of pk_word, with the key in the low KEY_W bits of that slot and the value in the VAL_W bits directly above it.
- R3: A word emitted without an end-of-stream pair holds floor(WORD_W/(KEY_W+VAL_W)) pairs (3 at the defaults), with pk_count equal to that number and pk_last 0.
- R4: Every pk_word bit above the last full slot is 0.
- R5: A pair accepted with in_last=1 closes its word at once: pk_count is the number of pairs in that word (1 up to the slot count) and pk_last is 1.
- R6: The unpacker emits the first uw_count slots of a word, slot 0 first, with out_key and out_val taken from the slot layout of R2; out_last is 1 only on the final emitted pair of a word that arrived with uw_last=1.
- R7: A word arriving with uw_count=0 is accepted and produces no output pair.
- R8: While a valid output is held back by its ready input, its data stays unchanged, and no pair is lost or duplicated under any pattern of stalls.
- R9: With in_valid held high and pk_ready held high, in_ready stays 1 every cycle, so pairs enter at one per cycle and a full word leaves every slot-count cycles.
- R10: With out_ready held high, the unpacker accepts the next word in the cycle that the last pair of the current word leaves, so back-to-back full words produce one pair on every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Packer can take the pair |
| in_key | input | KEY_W | Key of the input pair |
| in_val | input | VAL_W | Value of the input pair |
| in_last | input | 1 | Pair ends the stream; flushes the word |
| pk_valid | output | 1 | Packed word valid |
| pk_ready | input | 1 | Consumer takes the packed word |
| pk_word | output | WORD_W | Packed word |
| pk_count | output | CNT_W | Number of pairs in pk_word |
| pk_last | output | 1 | Word ends a stream |
| uw_valid | input | 1 | Word to unpack valid |
| uw_ready | output | 1 | Unpacker can take the word |
| uw_word | input | WORD_W | Word to unpack |
| uw_count | input | CNT_W | Number of valid pairs in uw_word |
| uw_last | input | 1 | Word ends a stream |
| out_valid | output | 1 | Unpacked pair valid |
| out_ready | input | 1 | Consumer takes the pair |
| out_key | output | KEY_W | Key of the unpacked pair |
| out_val | output | VAL_W | Value of the unpacked pair |
| out_last | output | 1 | Final pair of a stream |

## Verification
On every cycle the assertions hold the packed and unpacked outputs steady under backpressure, keep pk_count within one to the slot count, force a short word to carry the end-of-stream flag and keep the unused top bits of each packed word at zero. The exact slot placement, the order of pairs after a round trip, the dropping of empty words and the gap-free rates on both sides only show up in the bench's scenarios, which compare every transferred word and pair with a model built from the requirements under random stalls and under directed full-speed runs.

// File: rtl/kv_bit_packer.sv
module kv_bit_packer #(
  parameter int KEY_W  = 34,
  parameter int VAL_W  = 32,
  parameter int WORD_W = 256,
  localparam int CNT_W = $clog2(WORD_W / (KEY_W + VAL_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [VAL_W-1:0]  in_val,
  input  logic              in_last,
  output logic              pk_valid,
  input  logic              pk_ready,
  output logic [WORD_W-1:0] pk_word,
  output logic [CNT_W-1:0]  pk_count,
  output logic              pk_last,
  input  logic              uw_valid,
  output logic              uw_ready,
  input  logic [WORD_W-1:0] uw_word,
  input  logic [CNT_W-1:0]  uw_count,
  input  logic              uw_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KEY_W-1:0]  out_key,
  output logic [VAL_W-1:0]  out_val,
  output logic              out_last
);

  localparam int PAIR_W = KEY_W + VAL_W;
  localparam int SLOTS  = WORD_W / PAIR_W;
  localparam int USED   = SLOTS * PAIR_W;

  // packing side
  logic [WORD_W-1:0] acc, placed;
  logic [CNT_W-1:0]  fill;
  logic              closes, take_in;

  always_comb begin
    placed = '0;
    for (int s = 0; s < SLOTS; s++)
      if (fill == CNT_W'(s)) placed[s*PAIR_W +: PAIR_W] = {in_val, in_key};
  end

  assign closes   = in_last || (fill == CNT_W'(SLOTS - 1));
  assign in_ready = !closes || !pk_valid || pk_ready;
  assign take_in  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      fill     <= '0;
      pk_valid <= 1'b0;
      pk_word  <= '0;
      pk_count <= '0;
      pk_last  <= 1'b0;
    end else begin
      if (pk_valid && pk_ready) pk_valid <= 1'b0;
      if (take_in) begin
        if (closes) begin
          pk_word  <= acc | placed;
          pk_count <= fill + CNT_W'(1);
          pk_last  <= in_last;
          pk_valid <= 1'b1;
          acc      <= '0;
          fill     <= '0;
        end else begin
          acc  <= acc | placed;
          fill <= fill + CNT_W'(1);
        end
      end
    end
  end

  // unpacking side
  logic [WORD_W-1:0] hold_w;
  logic [CNT_W-1:0]  hold_n, idx;
  logic              hold_l, fin;
  logic [PAIR_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int s = 0; s < SLOTS; s++)
      if (idx == CNT_W'(s)) sel = hold_w[s*PAIR_W +: PAIR_W];
  end

  assign fin      = (idx == hold_n - CNT_W'(1));
  assign out_key  = sel[KEY_W-1:0];
  assign out_val  = sel[PAIR_W-1:KEY_W];
  assign out_last = hold_l && fin;
  assign uw_ready = !out_valid || (out_ready && fin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hold_w    <= '0;
      hold_n    <= '0;
      hold_l    <= 1'b0;
      idx       <= '0;
    end else begin
      if (out_valid && out_ready) begin
        if (fin) out_valid <= 1'b0;
        else     idx <= idx + CNT_W'(1);
      end
      if (uw_valid && uw_ready && uw_count != '0) begin
        out_valid <= 1'b1;
        hold_w    <= uw_word;
        hold_n    <= uw_count;
        hold_l    <= uw_last;
        idx       <= '0;
      end
    end
  end

  generate
    if (USED < WORD_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^hold_w[WORD_W-1:USED];
      // R4
      pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> pk_word[WORD_W-1:USED] == '0);
    end
  endgenerate

  // R8
  pk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_word) && $stable(pk_count) && $stable(pk_last));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_val) && $stable(out_last));
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |-> pk_count != '0 && pk_count <= CNT_W'(SLOTS));
  // R5
  short_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && pk_count < CNT_W'(SLOTS) |-> pk_last);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !pk_valid && !out_valid);

endmodule

// File: tb/test_kv_bit_packer.sv
`timescale 1ns/100ps
module test_kv_bit_packer;
  localparam int KW = 34;
  localparam int VW = 32;
  localparam int WW = 256;
  localparam int PW = KW + VW;
  localparam int NS = WW / PW;
  localparam int CW = $clog2(NS + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [KW-1:0] in_key = '0;
  logic [VW-1:0] in_val = '0;
  logic pk_valid, pk_ready, pk_last;
  logic [WW-1:0] pk_word;
  logic [CW-1:0] pk_count;
  logic uw_valid, uw_ready, uw_last;
  logic [WW-1:0] uw_word;
  logic [CW-1:0] uw_count;
  logic out_valid, out_ready = 0, out_last;
  logic [KW-1:0] out_key;
  logic [VW-1:0] out_val;

  logic gate = 0, direct = 0, d_valid = 0, d_last = 0;
  logic [WW-1:0] d_word = '0;
  logic [CW-1:0] d_count = '0;

  assign uw_valid = direct ? d_valid : (pk_valid && gate);
  assign uw_word  = direct ? d_word  : pk_word;
  assign uw_count = direct ? d_count : pk_count;
  assign uw_last  = direct ? d_last  : pk_last;
  assign pk_ready = direct ? 1'b0    : (uw_ready && gate);

  kv_bit_packer #(.KEY_W(KW), .VAL_W(VW), .WORD_W(WW)) i_kv_bit_packer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_val(in_val), .in_last(in_last),
    .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_word(pk_word), .pk_count(pk_count), .pk_last(pk_last),
    .uw_valid(uw_valid), .uw_ready(uw_ready), .uw_word(uw_word), .uw_count(uw_count), .uw_last(uw_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key), .out_val(out_val), .out_last(out_last));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, n_words = 0, n_stall = 0, n_out = 0, cyc_all = 0;
  bit done = 0;

  logic [KW-1:0] mk [NS];
  logic [VW-1:0] mv [NS];
  int mn = 0;
  logic [WW-1:0] exp_w [$];
  int            exp_c [$];
  bit            exp_l [$];
  logic [PW-1:0] exp_p [$];
  bit            exp_pl [$];

  function automatic logic [WW-1:0] model_word(int n);
    logic [WW-1:0] w = '0;
    for (int i = 0; i < n; i++) begin
      w[i*PW +: KW]      = mk[i];
      w[i*PW + KW +: VW] = mv[i];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (!direct && in_valid && in_ready) begin
      mk[mn] = in_key; mv[mn] = in_val; mn++;
      exp_p.push_back({in_val, in_key});
      exp_pl.push_back(in_last);
      if (mn == NS || in_last) begin
        exp_w.push_back(model_word(mn)); exp_c.push_back(mn); exp_l.push_back(in_last);
        mn = 0;
      end
    end
    if (!direct && in_valid && !in_ready) n_stall++;
    if (!direct && pk_valid && pk_ready) begin
      n_words++;
      if (exp_w.size() == 0) check(0, "R8 extra word", pk_word, '0);
      else begin
        logic [WW-1:0] ew = exp_w.pop_front();
        int ec = exp_c.pop_front();
        bit el = exp_l.pop_front();
        check(pk_word == ew, "R2 slot layout", pk_word, ew);
        check(pk_count == CW'(ec) && pk_last == el, (ec < NS) ? "R5 flush count/last" : "R3 full count/last",
              WW'({pk_count, pk_last}), WW'({CW'(ec), el}));
        check(pk_word[WW-1:NS*PW] == '0, "R4 unused bits", WW'(pk_word[WW-1:NS*PW]), '0);
      end
    end
    if (out_valid && out_ready) begin
      n_out++;
      if (exp_p.size() == 0) check(0, "R7 unexpected pair", WW'({out_val, out_key}), '0);
      else begin
        logic [PW-1:0] ep = exp_p.pop_front();
        bit el = exp_pl.pop_front();
        check({out_val, out_key} == ep, "R6 pair order/content", WW'({out_val, out_key}), WW'(ep));
        check(out_last == el, "R6 out_last", WW'(out_last), WW'(el));
      end
    end
  endtask

  task automatic run_stream(int n, int pv, int pg, int pr, int lastmod);
    bit have = 0;
    int sent = 0;
    direct = 0;
    for (int cyc = 0; cyc < 20000 && (sent < n || have || exp_p.size() != 0); cyc++) begin
      @(negedge clk);
      if (!have && sent < n && int'($urandom % 100) < pv) begin
        logic [63:0] r = {$urandom, $urandom};
        in_key  = r[KW-1:0];
        in_val  = $urandom;
        in_last = (sent == n - 1) || (lastmod != 0 && ($urandom % lastmod) == 0);
        have = 1; sent++;
      end
      in_valid  = have;
      gate      = int'($urandom % 100) < pg;
      out_ready = int'($urandom % 100) < pr;
      #2;
      observe();
      if (in_valid && in_ready) have = 0;
    end
    @(negedge clk);
    in_valid = 0;
    check(exp_p.size() == 0 && exp_w.size() == 0, "R8 all drained", WW'(exp_p.size()), '0);
  endtask

  logic [WW-1:0] dw [4];
  logic [CW-1:0] dc [4];
  bit            dl [4];
  int first_out, last_out;

  task automatic run_direct(int nw, int tail);
    int w = 0;
    direct = 1; first_out = -1; last_out = -1;
    for (int cyc = 0; cyc < 200 && (w < nw || exp_p.size() != 0 || tail > 0); cyc++) begin
      @(negedge clk);
      if (w >= nw && exp_p.size() == 0) tail--;
      d_valid = (w < nw);
      d_word  = dw[w < nw ? w : 0];
      d_count = dc[w < nw ? w : 0];
      d_last  = dl[w < nw ? w : 0];
      out_ready = 1;
      #2;
      if (out_valid) begin
        if (first_out < 0) first_out = cyc;
        last_out = cyc;
      end
      observe();
      if (d_valid && uw_ready) w++;
    end
    @(negedge clk);
    d_valid = 0;
  endtask

  task automatic fill_word(int slot_w, int cnt, bit lst);
    for (int i = 0; i < NS; i++) begin
      logic [63:0] r = {$urandom, $urandom};
      mk[i] = r[KW-1:0]; mv[i] = $urandom;
    end
    dw[slot_w] = model_word(NS);
    dc[slot_w] = CW'(cnt);
    dl[slot_w] = lst;
    for (int i = 0; i < cnt; i++) begin
      exp_p.push_back({mv[i], mk[i]});
      exp_pl.push_back(lst && i == cnt - 1);
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected=<150000 cycles", cyc_all);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    check(!pk_valid && !out_valid && in_ready && uw_ready, "R1 reset outputs",
          WW'({pk_valid, out_valid, in_ready, uw_ready}), WW'(4'b0011));
    @(negedge clk); rst_n = 1;
    #2;
    check(!pk_valid && !out_valid && in_ready && uw_ready, "R1 after release",
          WW'({pk_valid, out_valid, in_ready, uw_ready}), WW'(4'b0011));

    // R5 single pair stream, R3/R5 exactly one full word ending the stream
    run_stream(1, 100, 100, 100, 0);
    run_stream(NS, 100, 100, 100, 0);
    run_stream(NS + 1, 100, 100, 100, 0);

    // R9 full-speed packing
    n_stall = 0; n_words = 0;
    run_stream(10 * NS, 100, 100, 100, 0);
    check(n_stall == 0, "R9 no input stall", WW'(n_stall), '0);
    check(n_words == 10, "R9 word count", WW'(n_words), WW'(10));

    // R8 random stalls with random stream ends
    run_stream(400, 80, 70, 70, 8);
    run_stream(200, 100, 30, 40, 5);

    // R10 back-to-back full words
    n_out = 0;
    for (int i = 0; i < 4; i++) fill_word(i, NS, i == 3);
    run_direct(4, 0);
    check(n_out == 4 * NS && last_out - first_out + 1 == 4 * NS, "R10 gap-free unpack",
          WW'(last_out - first_out + 1), WW'(4 * NS));

    // R7 empty word produces nothing, then a short word
    n_out = 0;
    fill_word(0, 0, 1'b1);
    run_direct(1, 5);
    check(n_out == 0, "R7 empty word dropped", WW'(n_out), '0);
    fill_word(0, 2, 1'b0);
    run_direct(1, 3);
    check(n_out == 2, "R6 short word pair count", WW'(n_out), WW'(2));
    #2;
    check(!out_valid, "R6 idle after short word", WW'(out_valid), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule